// File: doc/BRIEF.md
# Serial Frame Start Controller

This block decides the cycle in which a serial receiver or transmitter begins a frame. It watches a frame-sync input pin, a start pulse coming from the partner direction and the end-of-transfer indication of its own shifter. A four-bit trigger mode selects what counts as a start event. A programmable start delay can be placed between the event and the start. The block emits a one-cycle start pulse to the downstream framing logic. Independently, it can produce a periodic frame-sync pulse by dividing the bit clock.

All sequencing advances on a bit clock enable. An optional gate lets that enable pass only while the frame-sync pin is high. The gated enable is also driven out, so the shifter can run from it. The trigger mode, delay, period and gate option are static configuration inputs. Dropping the enable input returns the block to its idle state.

Top module: `fsc_start_ctrl`

## Requirements
- R1: While `en_i` is low, or in the cycle after reset, `start_o` and `period_o` are low. The delay counter, period counter, busy state and frame-sync history are cleared, so after enable is raised again the period divider counts from zero.
- R2: Mode 0 (continuous) starts at the first qualified bit enable (`ce_o` high) once the unit is idle: right after enable, and again after each `done_i`.
- R3: Mode 1 starts on a qualified bit enable in which `partner_i` is high.
- R4: Mode 2 starts on a qualified bit enable that samples `fs_i` low. Mode 3 does the same when it samples `fs_i` high.
- R5: Mode 4 starts when the sampled `fs_i` is 0 and the previous sample was 1. Mode 5 starts on the opposite transition. A transition needs a previous sample taken since enable was raised.
- R6: Modes 6 and 7 start when the sampled `fs_i` differs from the previous sample, in either direction. The same history rule as R5 applies.
- R7: With `dly_i` = D > 0, a trigger loads a counter. `start_o` rises in the cycle after the D-th later qualified bit enable. With D = 0 it rises in the cycle after the trigger. The delay applies equally in mode 1.
- R8: After a start pulse the unit is busy until `done_i`. Triggers seen while busy or while a delay count runs are ignored. A `done_i` takes effect from the next cycle.
- R9: Trigger mode values 8 to 15 never produce a start.
- R10: With `per_i` = 0, `period_o` stays low. With `per_i` = P > 0, `period_o` pulses for one cycle after every 2×(P+1) qualified bit enables, counted from enable.
- R11: `ce_o` equals `bit_en_i` when `gate_i` is 0. When `gate_i` is 1, it equals `bit_en_i` AND `fs_i`.
- R12: `start_o` is registered and lasts exactly one cycle per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Unit enable; low clears all state |
| bit_en_i | input | 1 | Bit clock enable |
| fs_i | input | 1 | Frame-sync pin level |
| partner_i | input | 1 | Start pulse from the opposite direction |
| done_i | input | 1 | End of the current transfer |
| mode_i | input | 4 | Trigger mode (0..7 valid) |
| dly_i | input | DLY_W | Start delay in bit enables |
| per_i | input | PER_W | Period divider setting |
| gate_i | input | 1 | Gate bit enable with high `fs_i` |
| ce_o | output | 1 | Qualified bit enable |
| start_o | output | 1 | One-cycle frame start pulse |
| period_o | output | 1 | One-cycle periodic frame-sync pulse |

## Verification
The bench builds the block with its default eight-bit delay and period fields. It programs only small delays (0 to 6) and periods (0 to 5), so each delay window and each divider wrap occurs many times within a short run. Bursts of randomly gated bit enables make the counters stall between steps. Random enable drops exercise the cleared-history and restarted-divider behaviour. All eight trigger modes and a few undefined codes are rotated through.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [3:0] {
        TRG_FREE    = 4'd0,
        TRG_PARTNER = 4'd1,
        TRG_LOW     = 4'd2,
        TRG_HIGH    = 4'd3,
        TRG_FALL    = 4'd4,
        TRG_RISE    = 4'd5,
        TRG_CHANGE  = 4'd6,
        TRG_EDGE    = 4'd7
    } trig_mode_e;

    // Sampled history of the frame-sync pin.
    typedef struct packed {
        logic lvl;
        logic valid;
    } fs_hist_t;

    // Decides whether the current sample is a start event for the given mode.
    function automatic logic start_hit(input logic [3:0] mode,
                                       input logic       lvl,
                                       input fs_hist_t   h,
                                       input logic       partner);
        logic moved;
        moved = h.valid && (h.lvl != lvl);
        case (mode)
            TRG_FREE:    start_hit = 1'b1;
            TRG_PARTNER: start_hit = partner;
            TRG_LOW:     start_hit = !lvl;
            TRG_HIGH:    start_hit = lvl;
            TRG_FALL:    start_hit = moved && !lvl;
            TRG_RISE:    start_hit = moved && lvl;
            TRG_CHANGE,
            TRG_EDGE:    start_hit = moved;
            default:     start_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fsc_trigger.sv
module fsc_trigger
    import fsc_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ce,
    input  logic              fs,
    input  logic              partner,
    input  logic [MODE_W-1:0] mode,
    output logic              trig
);
    fs_hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist_q <= '0;
        end else if (ce) begin
            hist_q <= '{lvl: fs, valid: 1'b1};
        end
    end

    assign trig = ce && start_hit(4'(mode), fs, hist_q, partner);

    // R5
    hist_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !hist_q.valid);

endmodule

// File: rtl/fsc_delay.sv
module fsc_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ce,
    input  logic             trig,
    input  logic             done,
    input  logic [DLY_W-1:0] dly,
    output logic             start
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] cnt_q;
    logic             busy_q;
    logic             fire_q;
    logic             fire_d;
    logic             accept;

    assign accept = ce && (cnt_q == '0) && !busy_q && trig;

    always_comb begin
        fire_d = 1'b0;
        if (ce && cnt_q != '0) begin
            fire_d = (cnt_q == ONE);
        end else if (accept && dly == '0) begin
            fire_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= fire_d;
            busy_q <= fire_d || (busy_q && !done);
            if (ce && cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end else if (accept && dly != '0) begin
                cnt_q <= dly;
            end
        end
    end

    assign start = fire_q;

    // R8
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> !busy_q);

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

endmodule

// File: rtl/fsc_period.sv
module fsc_period #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ce,
    input  logic [PER_W-1:0] per,
    output logic             pulse
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] limit;
    logic             pulse_q;

    assign limit = {per, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || !en || per == '0) begin
            pc_q    <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (ce) begin
                if (pc_q >= limit) begin
                    pc_q    <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    pc_q <= pc_q + CNT_W'(1);
                end
            end
        end
    end

    assign pulse = pulse_q;

    // R10
    per_off_chk: assert property (@(posedge clk) disable iff (rst)
        (per == '0) |=> !pulse_q);

    // R10
    per_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/fsc_start_ctrl.sv
module fsc_start_ctrl
    import fsc_pkg::*;
#(
    parameter int MODE_W = 4,
    parameter int DLY_W  = 8,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              bit_en_i,
    input  logic              fs_i,
    input  logic              partner_i,
    input  logic              done_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [PER_W-1:0]  per_i,
    input  logic              gate_i,
    output logic              ce_o,
    output logic              start_o,
    output logic              period_o
);
    logic ce;
    logic trig;

    assign ce   = bit_en_i && (!gate_i || fs_i);
    assign ce_o = ce;

    fsc_trigger #(.MODE_W(MODE_W)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .ce      (ce),
        .fs      (fs_i),
        .partner (partner_i),
        .mode    (mode_i),
        .trig    (trig)
    );

    fsc_delay #(.DLY_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .en    (en_i),
        .ce    (ce),
        .trig  (trig),
        .done  (done_i),
        .dly   (dly_i),
        .start (start_o)
    );

    fsc_period #(.PER_W(PER_W)) u_per (
        .clk   (clk),
        .rst   (rst),
        .en    (en_i),
        .ce    (ce),
        .per   (per_i),
        .pulse (period_o)
    );

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!start_o && !period_o));

endmodule

// File: tb/fsc_start_ctrl_bench.sv
module fsc_start_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, bit_en = 1'b0, fs = 1'b0, partner = 1'b0, done = 1'b0, gate = 1'b0;
    logic [3:0] mode = 4'd0;
    logic [7:0] dly = 8'd0, per = 8'd0;
    logic       ce_o, start_o, period_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference model state
    int m_cnt = 0;
    bit m_busy = 0, m_fsq = 0, m_hv = 0;
    int m_pc = 0;
    bit e_start = 0, e_per = 0;

    always #10 clk = ~clk;

    fsc_start_ctrl u_fsc_start_ctrl (
        .clk(clk), .rst(rst), .en_i(en), .bit_en_i(bit_en), .fs_i(fs),
        .partner_i(partner), .done_i(done), .mode_i(mode), .dly_i(dly),
        .per_i(per), .gate_i(gate), .ce_o(ce_o), .start_o(start_o),
        .period_o(period_o)
    );

    function automatic bit exp_ce(bit b, bit g, bit f);
        return b && (!g || f);
    endfunction

    function automatic bit exp_trig(int md, bit f, bit prev, bit hv, bit p);
        bit moved = hv && (prev != f);
        case (md)
            0: return 1;
            1: return p;
            2: return !f;
            3: return f;
            4: return moved && !f;
            5: return moved && f;
            6, 7: return moved;
            default: return 0;
        endcase
    endfunction

    function automatic string mode_tag(int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            6, 7: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_busy = 0; m_fsq = 0; m_hv = 0; m_pc = 0;
        e_start = 0; e_per = 0;
    endtask

    task automatic model_step();
        bit c, fire, t;
        c = exp_ce(bit_en, gate, fs);
        fire = 0;
        e_per = 0;
        if (rst || !en) begin
            model_reset();
            return;
        end
        if (c) begin
            t = exp_trig(int'(mode), fs, m_fsq, m_hv, partner);
            if (m_cnt != 0) begin
                fire = (m_cnt == 1);
                m_cnt--;
            end else if (!m_busy && t) begin
                if (dly == 0) fire = 1;
                else m_cnt = int'(dly);
            end
            m_fsq = fs;
            m_hv = 1;
        end
        if (per == 0) begin
            m_pc = 0;
        end else if (c) begin
            if (m_pc >= 2 * int'(per) + 1) begin
                m_pc = 0;
                e_per = 1;
            end else begin
                m_pc++;
            end
        end
        m_busy = fire || (m_busy && !done);
        e_start = fire;
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic cyc(string tag);
        #1;
        check(gate ? "R11" : tag, "ce_o", int'(ce_o), int'(exp_ce(bit_en, gate, fs)));
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, "start_o", int'(start_o), int'(e_start));
        check(en ? "R10" : "R1", "period_o", int'(period_o), int'(e_per));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        rst = 1'b1;
        repeat (3) cyc("R1");
        rst = 1'b0;
        check("R1", "start_o after reset", int'(start_o), 0);
        check("R1", "period_o after reset", int'(period_o), 0);

        // R11: gating follows fs while enabled
        en = 1; gate = 1; mode = 4'd9; bit_en = 1;
        for (int i = 0; i < 8; i++) begin fs = i[1]; cyc("R11"); end
        gate = 0;

        // R9: undefined mode with a busy toggling pin
        for (int i = 0; i < 20; i++) begin fs = i[0]; cyc("R9"); end
        mode = 4'd15;
        for (int i = 0; i < 10; i++) begin fs = i[0]; cyc("R9"); end

        // R7: delay 5 on a high level, with sparse bit enables
        mode = 4'd3; dly = 8'd5; fs = 1;
        for (int i = 0; i < 16; i++) begin bit_en = (i % 2 == 0); cyc("R7"); end
        done = 1; cyc("R8"); done = 0;
        // R7: delay applied to partner start
        mode = 4'd1; dly = 8'd3; bit_en = 1;
        partner = 1; cyc("R7"); partner = 0;
        for (int i = 0; i < 6; i++) cyc("R7");
        done = 1; cyc("R8"); done = 0;
        // R12: delay zero fires on next cycle
        dly = 8'd0; partner = 1; cyc("R12"); partner = 0; cyc("R12"); cyc("R8");

        // R10: period 3 then 0, then restart after disable
        per = 8'd3; mode = 4'd9;
        for (int i = 0; i < 20; i++) cyc("R10");
        per = 8'd0;
        for (int i = 0; i < 10; i++) cyc("R10");
        per = 8'd2; en = 0; cyc("R1"); en = 1;
        for (int i = 0; i < 14; i++) cyc("R1");

        // Random mix across all modes
        for (int seg = 0; seg < 60; seg++) begin
            mode = 4'($urandom_range(0, 9));
            dly = 8'($urandom_range(0, 6));
            per = 8'($urandom_range(0, 5));
            gate = ($urandom_range(0, 4) == 0);
            for (int i = 0; i < 60; i++) begin
                bit_en = ($urandom_range(0, 2) != 0);
                if ($urandom_range(0, 3) == 0) fs = ~fs;
                partner = ($urandom_range(0, 5) == 0);
                done = m_busy && ($urandom_range(0, 4) == 0);
                en = ($urandom_range(0, 150) != 0);
                cyc(m_busy ? "R8" : (dly != 0 ? "R7" : mode_tag(int'(mode))));
            end
        end
        done = 0; partner = 0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule